// File: doc/BRIEF.md
# Status Register and Branch Control Unit

This unit holds the 8-bit status word of a small 32-bit register machine and owns its program counter. Each cycle in which an instruction retires (`step_valid` high) the unit advances the PC by the instruction's length, takes a PC-relative branch on any status bit, or performs a register jump that can also produce a return address for the register file. Status flags arrive from the ALU as Zero, Carry and Negative results, and bit-manipulation instructions aimed at register zero can set or clear any group of status bits through an 8-bit mask.

The decoder supplies the flow operation, the instruction length code, the selected status bit, the branch offset and the jump target together with the two "register is zero" qualifiers. The register file receives the link value and its write strobe. Only the low 24 bits of the PC are presented as the fetch address, while the full 32-bit value is kept and wraps modulo 2^32. The PC, status word and link outputs all come directly from registers.

Top module: `sr_branch_unit`

## Requirements
- R1: Synchronous active-high reset sets `pc` to `RESET_PC` (default 0x00001000), `sr` to 0 and `link_we` to 0.
- R2: Status bit 0 is Zero, bit 1 is Carry, bit 2 is Negative, bits 4..7 are user flags; bit 3 always reads 0, whatever is written to it.
- R3: When `alu_we` is high and no mask operation is present, Z and N take `alu_z` and `alu_n` at the next edge; C takes `alu_c` only when `alu_c_en` is high and otherwise keeps its value.
- R4: `msk_op` = 1 (set) ORs `msk_val` into the status word; `msk_op` = 2 (clear) clears every status bit whose `msk_val` bit is 1; `msk_op` 0 and 3 do nothing; bits outside the mask are kept.
- R5: If a mask operation and an ALU update arrive in the same cycle, the whole ALU update is dropped and only the mask operation takes effect.
- R6: `flow_op` = 1 (branch if clear) is taken when status bit `br_sel` is 0; `flow_op` = 2 (branch if set) is taken when it is 1; the test uses the status word held before the edge.
- R7: A taken branch loads `pc + 2 + sign_extend(br_off) * 2`; an untaken branch loads `pc + 2`.
- R8: `flow_op` = 0 (sequential) adds `2 * (len_code + 1)`: code 0 gives 2, 1 gives 4 (loads, stores, 16-bit immediate), 2 gives 6 (32-bit immediate), 3 gives 8.
- R9: `flow_op` = 3 (jump and link) loads `pc` from `jal_target` and, one cycle later, pulses `link_we` with `link_val` = old `pc + 2`; branches and sequential steps never pulse `link_we`.
- R10: A jump and link with `jal_dst_r0` high writes no link; with `jal_src_r0` high the PC becomes `pc + 2` and the link is still written.
- R11: `fetch_addr` equals the low 24 bits of `pc`; the 32-bit PC wraps from 0xFFFFFFFE by +2 to 0.
- R12: With `step_valid` low the PC holds and `link_we` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_valid | input | 1 | An instruction retires this cycle |
| flow_op | input | 2 | 0 sequential, 1 branch if clear, 2 branch if set, 3 jump and link |
| len_code | input | 2 | Instruction length code for sequential steps |
| br_sel | input | 3 | Status bit tested by a branch |
| br_off | input | 8 | Signed branch offset in two-byte words |
| jal_target | input | 32 | Jump target read from the source register |
| jal_src_r0 | input | 1 | Jump source is register zero |
| jal_dst_r0 | input | 1 | Link destination is register zero |
| alu_we | input | 1 | ALU flag update valid |
| alu_c_en | input | 1 | ALU update includes Carry |
| alu_z | input | 1 | ALU Zero result |
| alu_c | input | 1 | ALU Carry result |
| alu_n | input | 1 | ALU Negative result |
| msk_op | input | 2 | 0 none, 1 set by mask, 2 clear by mask, 3 none |
| msk_val | input | 8 | Status bit mask |
| pc | output | 32 | Program counter |
| fetch_addr | output | 24 | Low 24 bits of the PC |
| sr | output | 8 | Status word |
| link_we | output | 1 | Link write strobe |
| link_val | output | 32 | Return address for the link register |

## Verification
Every result of this unit appears one edge after its stimulus: PC, status word and link strobe are all registered, so a step presented after a falling edge is visible at the next falling edge. The bench drives inputs on the falling edge, returns them to idle on the next falling edge and samples there, so each check sees exactly one retired step. Branch conditions use the status word from before the same edge, so a vector that changes flags and branches at once checks the old flag value for the branch and the new one for `sr`. The link strobe is a single-cycle pulse and is sampled in that one cycle only.

// File: rtl/sbu_pkg.sv
package sbu_pkg;
  typedef enum logic [1:0] {
    FL_SEQ  = 2'd0,
    FL_BCLR = 2'd1,
    FL_BSET = 2'd2,
    FL_JAL  = 2'd3
  } flow_e;

  typedef enum logic [1:0] {
    MK_NONE = 2'd0,
    MK_SET  = 2'd1,
    MK_CLR  = 2'd2,
    MK_RSV  = 2'd3
  } msk_e;

  localparam int unsigned BIT_Z = 0;
  localparam int unsigned BIT_C = 1;
  localparam int unsigned BIT_N = 2;
  localparam int unsigned BIT_RSV = 3;
endpackage

// File: rtl/sbu_status_reg.sv
module sbu_status_reg
  import sbu_pkg::*;
#(
  parameter int unsigned SR_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            alu_we,
  input  logic            alu_c_en,
  input  logic            alu_z,
  input  logic            alu_c,
  input  logic            alu_n,
  input  msk_e            msk_op,
  input  logic [SR_W-1:0] msk_val,
  output logic [SR_W-1:0] sr_q
);
  localparam logic [SR_W-1:0] KEEP = ~(SR_W'(1) << BIT_RSV);

  logic [SR_W-1:0] sr_d;

  always_comb begin
    sr_d = sr_q;
    unique case (msk_op)
      MK_SET:  sr_d = sr_q | msk_val;
      MK_CLR:  sr_d = sr_q & ~msk_val;
      default: begin
        if (alu_we) begin
          sr_d[BIT_Z] = alu_z;
          sr_d[BIT_N] = alu_n;
          if (alu_c_en) sr_d[BIT_C] = alu_c;
        end
      end
    endcase
    sr_d = sr_d & KEEP;
  end

  always_ff @(posedge clk) begin
    if (rst) sr_q <= '0;
    else     sr_q <= sr_d;
  end
endmodule

// File: rtl/sbu_branch_cond.sv
module sbu_branch_cond
  import sbu_pkg::*;
#(
  parameter int unsigned SR_W  = 8,
  parameter int unsigned SEL_W = $clog2(SR_W)
) (
  input  logic [SR_W-1:0]  sr,
  input  flow_e            flow,
  input  logic [SEL_W-1:0] sel,
  output logic             take
);
  logic bit_val;

  assign bit_val = sr[sel];

  always_comb begin
    unique case (flow)
      FL_BSET: take = bit_val;
      FL_BCLR: take = ~bit_val;
      default: take = 1'b0;
    endcase
  end
endmodule

// File: rtl/sbu_pc_next.sv
module sbu_pc_next
  import sbu_pkg::*;
#(
  parameter int unsigned PC_W  = 32,
  parameter int unsigned OFF_W = 8,
  parameter int unsigned LEN_W = 2
) (
  input  logic [PC_W-1:0]  pc,
  input  flow_e            flow,
  input  logic [LEN_W-1:0] len,
  input  logic             take,
  input  logic [OFF_W-1:0] off,
  input  logic [PC_W-1:0]  target,
  input  logic             src_r0,
  input  logic             dst_r0,
  output logic [PC_W-1:0]  pc_nxt,
  output logic [PC_W-1:0]  link_nxt,
  output logic             link_we_nxt
);
  localparam int unsigned EXT_W = PC_W - OFF_W - 1;

  logic [PC_W-1:0] step_bytes;
  logic [PC_W-1:0] pc_plus2;
  logic [PC_W-1:0] off_bytes;

  assign step_bytes = (PC_W'(len) + PC_W'(1)) << 1;
  assign pc_plus2   = pc + PC_W'(2);
  assign off_bytes  = {{EXT_W{off[OFF_W-1]}}, off, 1'b0};
  assign link_nxt   = pc_plus2;

  always_comb begin
    link_we_nxt = 1'b0;
    unique case (flow)
      FL_SEQ:  pc_nxt = pc + step_bytes;
      FL_BCLR,
      FL_BSET: pc_nxt = take ? (pc_plus2 + off_bytes) : pc_plus2;
      FL_JAL: begin
        pc_nxt      = src_r0 ? pc_plus2 : target;
        link_we_nxt = ~dst_r0;
      end
      default: pc_nxt = pc_plus2;
    endcase
  end
endmodule

// File: rtl/sr_branch_unit.sv
module sr_branch_unit
  import sbu_pkg::*;
#(
  parameter int unsigned PC_W     = 32,
  parameter int unsigned ADDR_W   = 24,
  parameter int unsigned SR_W     = 8,
  parameter int unsigned OFF_W    = 8,
  parameter int unsigned LEN_W    = 2,
  parameter logic [31:0] RESET_PC = 32'h0000_1000,
  localparam int unsigned SEL_W   = $clog2(SR_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step_valid,
  input  logic [1:0]        flow_op,
  input  logic [LEN_W-1:0]  len_code,
  input  logic [SEL_W-1:0]  br_sel,
  input  logic [OFF_W-1:0]  br_off,
  input  logic [PC_W-1:0]   jal_target,
  input  logic              jal_src_r0,
  input  logic              jal_dst_r0,
  input  logic              alu_we,
  input  logic              alu_c_en,
  input  logic              alu_z,
  input  logic              alu_c,
  input  logic              alu_n,
  input  logic [1:0]        msk_op,
  input  logic [SR_W-1:0]   msk_val,
  output logic [PC_W-1:0]   pc,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic [SR_W-1:0]   sr,
  output logic              link_we,
  output logic [PC_W-1:0]   link_val
);
  flow_e           flow;
  msk_e            mop;
  logic            take;
  logic [PC_W-1:0] pc_nxt;
  logic [PC_W-1:0] link_nxt;
  logic            link_we_nxt;

  assign flow = flow_e'(flow_op);
  assign mop  = msk_e'(msk_op);

  sbu_status_reg #(.SR_W(SR_W)) u_sr (
    .clk      (clk),
    .rst      (rst),
    .alu_we   (alu_we),
    .alu_c_en (alu_c_en),
    .alu_z    (alu_z),
    .alu_c    (alu_c),
    .alu_n    (alu_n),
    .msk_op   (mop),
    .msk_val  (msk_val),
    .sr_q     (sr)
  );

  sbu_branch_cond #(.SR_W(SR_W), .SEL_W(SEL_W)) u_cond (
    .sr   (sr),
    .flow (flow),
    .sel  (br_sel),
    .take (take)
  );

  sbu_pc_next #(.PC_W(PC_W), .OFF_W(OFF_W), .LEN_W(LEN_W)) u_next (
    .pc          (pc),
    .flow        (flow),
    .len         (len_code),
    .take        (take),
    .off         (br_off),
    .target      (jal_target),
    .src_r0      (jal_src_r0),
    .dst_r0      (jal_dst_r0),
    .pc_nxt      (pc_nxt),
    .link_nxt    (link_nxt),
    .link_we_nxt (link_we_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc       <= PC_W'(RESET_PC);
      link_we  <= 1'b0;
      link_val <= '0;
    end else begin
      link_we <= step_valid & link_we_nxt;
      if (step_valid) begin
        pc       <= pc_nxt;
        link_val <= link_nxt;
      end
    end
  end

  assign fetch_addr = pc[ADDR_W-1:0];
endmodule

// File: rtl/sbu_checker.sv
module sbu_checker (
  input logic        clk,
  input logic        rst,
  input logic        step_valid,
  input logic [1:0]  flow_op,
  input logic        jal_src_r0,
  input logic        jal_dst_r0,
  input logic        alu_we,
  input logic        alu_c_en,
  input logic [1:0]  msk_op,
  input logic [7:0]  msk_val,
  input logic [31:0] pc,
  input logic [7:0]  sr,
  input logic        link_we
);
  a_r2_bit3_zero: assert property (@(posedge clk) disable iff (rst)
    sr[3] == 1'b0);

  a_r4_set: assert property (@(posedge clk) disable iff (rst)
    (msk_op == 2'd1) |=> ((sr & $past(msk_val) & 8'hF7) == ($past(msk_val) & 8'hF7)));

  a_r4_clr: assert property (@(posedge clk) disable iff (rst)
    (msk_op == 2'd2) |=> ((sr & $past(msk_val)) == 8'h00));

  a_r5_mask_wins: assert property (@(posedge clk) disable iff (rst)
    (msk_op == 2'd1 || msk_op == 2'd2) |=>
      ((sr & ~$past(msk_val)) == ($past(sr) & ~$past(msk_val))));

  a_r3_carry_kept: assert property (@(posedge clk) disable iff (rst)
    (alu_we && !alu_c_en && msk_op == 2'd0) |=> (sr[1] == $past(sr[1])));

  a_r12_hold: assert property (@(posedge clk) disable iff (rst)
    !step_valid |=> ($stable(pc) && !link_we));

  a_r10_no_link: assert property (@(posedge clk) disable iff (rst)
    (step_valid && flow_op == 2'd3 && jal_dst_r0) |=> !link_we);

  a_r10_src_zero: assert property (@(posedge clk) disable iff (rst)
    (step_valid && flow_op == 2'd3 && jal_src_r0) |=> (pc == $past(pc) + 32'd2));
endmodule

bind sr_branch_unit sbu_checker u_chk (
  .clk        (clk),
  .rst        (rst),
  .step_valid (step_valid),
  .flow_op    (flow_op),
  .jal_src_r0 (jal_src_r0),
  .jal_dst_r0 (jal_dst_r0),
  .alu_we     (alu_we),
  .alu_c_en   (alu_c_en),
  .msk_op     (msk_op),
  .msk_val    (msk_val),
  .pc         (pc),
  .sr         (sr),
  .link_we    (link_we)
);

// File: tb/tb_sr_branch_unit.sv
`timescale 1ns/1ps
module tb_sr_branch_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        step_valid;
  logic [1:0]  flow_op;
  logic [1:0]  len_code;
  logic [2:0]  br_sel;
  logic [7:0]  br_off;
  logic [31:0] jal_target;
  logic        jal_src_r0, jal_dst_r0;
  logic        alu_we, alu_c_en, alu_z, alu_c, alu_n;
  logic [1:0]  msk_op;
  logic [7:0]  msk_val;
  logic [31:0] pc;
  logic [23:0] fetch_addr;
  logic [7:0]  sr;
  logic        link_we;
  logic [31:0] link_val;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;
  logic [31:0] exp_pc;

  always #10 clk = ~clk;

  sr_branch_unit dut (
    .clk(clk), .rst(rst), .step_valid(step_valid), .flow_op(flow_op),
    .len_code(len_code), .br_sel(br_sel), .br_off(br_off),
    .jal_target(jal_target), .jal_src_r0(jal_src_r0), .jal_dst_r0(jal_dst_r0),
    .alu_we(alu_we), .alu_c_en(alu_c_en), .alu_z(alu_z), .alu_c(alu_c),
    .alu_n(alu_n), .msk_op(msk_op), .msk_val(msk_val), .pc(pc),
    .fetch_addr(fetch_addr), .sr(sr), .link_we(link_we), .link_val(link_val)
  );

  typedef struct packed {
    logic [1:0]         mk;
    logic [7:0]         mv;
    logic [1:0]         fl;
    logic [1:0]         ln;
    logic [2:0]         bs;
    logic [7:0]         of;
    logic signed [31:0] dl;
    logic [7:0]         es;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 8'h00, 2'd0, 2'd0, 3'd0, 8'h00,    32'sd2, 8'h00},
    '{2'd0, 8'h00, 2'd0, 2'd1, 3'd0, 8'h00,    32'sd4, 8'h00},
    '{2'd0, 8'h00, 2'd0, 2'd2, 3'd0, 8'h00,    32'sd6, 8'h00},
    '{2'd0, 8'h00, 2'd0, 2'd3, 3'd0, 8'h00,    32'sd8, 8'h00},
    '{2'd1, 8'h18, 2'd1, 2'd0, 3'd0, 8'h05,   32'sd12, 8'h10},
    '{2'd0, 8'h00, 2'd2, 2'd0, 3'd4, 8'hFE,   -32'sd2, 8'h10},
    '{2'd2, 8'h10, 2'd1, 2'd0, 3'd4, 8'h10,    32'sd2, 8'h00},
    '{2'd1, 8'hFF, 2'd2, 2'd0, 3'd7, 8'h7F,    32'sd2, 8'hF7},
    '{2'd2, 8'h0F, 2'd2, 2'd0, 3'd7, 8'h80, -32'sd254, 8'hF0},
    '{2'd0, 8'h00, 2'd1, 2'd0, 3'd1, 8'h7F,  32'sd256, 8'hF0},
    '{2'd1, 8'h08, 2'd2, 2'd0, 3'd3, 8'h01,    32'sd2, 8'hF0},
    '{2'd0, 8'h00, 2'd1, 2'd0, 3'd3, 8'h01,    32'sd4, 8'hF0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    step_valid = 0; flow_op = 0; len_code = 0; br_sel = 0; br_off = 0;
    jal_target = 0; jal_src_r0 = 0; jal_dst_r0 = 0;
    alu_we = 0; alu_c_en = 0; alu_z = 0; alu_c = 0; alu_n = 0;
    msk_op = 0; msk_val = 0;
  endtask

  task automatic apply();
    @(negedge clk);
    idle();
  endtask

  task automatic jal(input logic [31:0] tgt, input logic s0, input logic d0);
    step_valid = 1; flow_op = 2'd3; jal_target = tgt; jal_src_r0 = s0; jal_dst_r0 = d0;
    apply();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    rst = 0;
    chk("R1 reset pc", pc, 32'h0000_1000);
    chk("R1 reset sr", {24'd0, sr}, 32'h0);
    chk("R1 reset link_we", {31'd0, link_we}, 32'h0);
    exp_pc = 32'h0000_1000;

    for (int i = 0; i < NV; i++) begin
      step_valid = 1; msk_op = VECS[i].mk; msk_val = VECS[i].mv;
      flow_op = VECS[i].fl; len_code = VECS[i].ln; br_sel = VECS[i].bs;
      br_off = VECS[i].of;
      apply();
      exp_pc = exp_pc + 32'(VECS[i].dl);
      chk("R6 R7 R8 vector pc", pc, exp_pc);
      chk("R2 R4 vector sr", {24'd0, sr}, {24'd0, VECS[i].es});
      chk("R9 no link on non-jump", {31'd0, link_we}, 32'h0);
    end

    // R3: ALU update with carry, then without carry
    alu_we = 1; alu_c_en = 1; alu_z = 1; alu_c = 1; alu_n = 1;
    apply();
    chk("R3 alu with carry", {24'd0, sr}, 32'hF7);
    alu_we = 1; alu_c_en = 0; alu_z = 0; alu_c = 0; alu_n = 1;
    apply();
    chk("R3 alu carry kept", {24'd0, sr}, 32'hF6);

    // R5: mask clear beats simultaneous ALU update
    alu_we = 1; alu_c_en = 1; alu_z = 1; alu_c = 1; alu_n = 1;
    msk_op = 2'd2; msk_val = 8'h06;
    apply();
    chk("R5 mask wins over alu", {24'd0, sr}, 32'hF0);

    // R4: reserved mask op code does nothing
    msk_op = 2'd3; msk_val = 8'hFF;
    apply();
    chk("R4 msk_op 3 ignored", {24'd0, sr}, 32'hF0);

    // R12: no step holds PC
    apply();
    chk("R12 pc holds", pc, exp_pc);
    chk("R12 no link", {31'd0, link_we}, 32'h0);

    // R9: jump and link
    jal(32'h00AB_CDE0, 1'b0, 1'b0);
    chk("R9 jal pc", pc, 32'h00AB_CDE0);
    chk("R9 link_we", {31'd0, link_we}, 32'h1);
    chk("R9 link_val", link_val, exp_pc + 32'd2);

    // R10: destination zero writes no link
    jal(32'h0000_1234, 1'b0, 1'b1);
    chk("R10 dst r0 pc", pc, 32'h0000_1234);
    chk("R10 dst r0 no link", {31'd0, link_we}, 32'h0);

    // R10: source zero keeps flow sequential, link written
    jal(32'hDEAD_BEE0, 1'b1, 1'b0);
    chk("R10 src r0 pc", pc, 32'h0000_1236);
    chk("R10 src r0 link_we", {31'd0, link_we}, 32'h1);
    chk("R10 src r0 link_val", link_val, 32'h0000_1236);

    // R11: fetch address and wrap
    jal(32'h1234_5678, 1'b0, 1'b1);
    chk("R11 fetch low 24", {8'd0, fetch_addr}, 32'h0034_5678);
    jal(32'hFFFF_FFFE, 1'b0, 1'b1);
    step_valid = 1; flow_op = 2'd0; len_code = 2'd0;
    apply();
    chk("R11 pc wrap", pc, 32'h0);
    chk("R11 fetch wrap", {8'd0, fetch_addr}, 32'h0);

    // R1: reset from a non-zero state
    rst = 1;
    apply();
    rst = 0;
    chk("R1 re-reset pc", pc, 32'h0000_1000);
    chk("R1 re-reset sr", {24'd0, sr}, 32'h0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule